// File: doc/BRIEF.md
# Fractional-Divisor Serial Transmitter

This block turns bytes into asynchronous serial frames on a single line. Its clock is the reference clock (24 MHz nominal). Each bit lasts 16 sub-bit slots, and each slot lasts (integer divisor + 1) reference cycles. A 3-bit fractional value adds one extra cycle to each of the first few slots, so the baud rate equals the reference divided by 16 × divisor + fraction + 16. A 6-bit line-format word sets the number of data bits, the number of stop bits and the parity.

Bytes enter through a valid/ready handshake into a one-byte holding stage. From there they move into the shift stage when a frame may begin. Two status outputs report whether the holding stage is free and whether the whole transmitter is idle. The block samples the divisor, the fraction and the line format at the moment a frame starts. A change made during a frame therefore first applies to the next frame. While the integer divisor is zero, no frame starts.

Top module: `frac_uart_tx`

## Requirements
- R1: Every bit of a frame lasts exactly 16 × (cfg_div + 1) + cfg_frac clock cycles. cfg_frac takes values 0 to 7, and each of the first cfg_frac sub-bit slots of a bit is one cycle longer.
- R2: While cfg_div is zero, no frame starts. txd stays high, and an accepted byte waits in the holding stage with buf_empty and tx_ready low. The frame begins on the first clock edge at which cfg_div is nonzero.
- R3: The number of data bits is cfg_line[1:0] + 5. Data bits go out least significant bit first. Byte bits above the word length are not sent and do not enter the parity.
- R4: cfg_line[2] = 1 gives two stop bits, and cfg_line[2] = 0 gives one stop bit.
- R5: cfg_line[5] = 1 appends a parity bit after the data. cfg_line[3] = 1 selects even parity (data ones plus parity bit is even), and 0 selects odd. cfg_line[4] has no effect, and cfg_line[3] has no effect when parity is off.
- R6: A frame is a low start bit, the data bits, the optional parity bit, then high stop bits. The line is high whenever no frame is in progress.
- R7: A byte is accepted on the edge where tx_valid and tx_ready are both high. One cycle later buf_empty and tx_empty are both low. buf_empty returns high on the edge where the byte enters the shift stage, which is the edge after acceptance when the line is idle. tx_empty returns high on the edge that ends the last stop bit when no byte is waiting.
- R8: After reset txd, tx_empty, buf_empty and tx_ready are all 1.
- R9: cfg_div, cfg_frac and cfg_line are sampled when a frame starts. Changes made during the frame do not alter that frame.
- R10: tx_ready equals buf_empty. A byte that is waiting when a frame ends starts its start bit on that same edge, with no idle cycle between frames, and tx_empty stays low throughout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | 16 | Integer baud divisor; zero halts the generator |
| cfg_frac | input | 3 | Extra reference cycles per bit |
| cfg_line | input | 6 | Line format: [1:0] length-5, [2] two stops, [3] even, [5] parity on |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Holding stage can take a byte |
| txd | output | 1 | Serial output, idle high |
| tx_empty | output | 1 | No frame in progress and nothing waiting |
| buf_empty | output | 1 | Holding stage is free |

## Verification
The status flags are due one cycle after the accepting edge. The start bit is due on the edge after that, or on the edge where cfg_div becomes nonzero, or on the edge that ends the previous frame's last stop bit. From then on, the line value at cycle c of a frame belongs to bit c / P, where P is the R1 period. The bench samples at every falling edge of every frame and compares txd and tx_empty with a bit vector it builds from the line-format rules. A one-cycle error in any bit's length therefore shows up as a mismatch. The flags are checked on the falling edge right after the accepting edge, the loading edge and the final stop edge.

// File: rtl/futx_pkg.sv
package futx_pkg;

    localparam int LINE_W = 6;
    localparam int DATA_W = 8;
    localparam int IDX_W  = $clog2(DATA_W);

    typedef enum logic [2:0] {
        FS_IDLE   = 3'd0,
        FS_START  = 3'd1,
        FS_DATA   = 3'd2,
        FS_PARITY = 3'd3,
        FS_STOP   = 3'd4
    } fstate_e;

    // decoded line format, captured once per frame
    typedef struct packed {
        logic [IDX_W-1:0] last_idx;   // index of the final data bit
        logic             two_stop;
        logic             par_en;
        logic             par_even;
    } fmt_t;

    function automatic fmt_t decode_line(input logic [LINE_W-1:0] line);
        fmt_t f;
        // word length - 1 = line[1:0] + 4
        f.last_idx = {1'b1, line[1:0]};
        f.two_stop = line[2];
        f.par_even = line[3];
        f.par_en   = line[5];
        return f;
    endfunction

endpackage

// File: rtl/futx_baud.sv
module futx_baud #(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 3,
    parameter int SLOTS  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic [DIV_W-1:0]  div,
    input  logic [FRAC_W-1:0] frac,
    output logic              bit_tick
);

    localparam int SLOT_W = $clog2(SLOTS);
    localparam int CNT_W  = DIV_W + 1;
    localparam int CMP_W  = (SLOT_W > FRAC_W) ? SLOT_W : FRAC_W;
    localparam int PER_W  = DIV_W + SLOT_W + 2;

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [CNT_W-1:0]  cyc;
    } bst_t;

    bst_t             bst_d, bst_q;
    logic             extra;
    logic [CNT_W-1:0] last_cyc;
    logic             slot_end;
    logic             last_slot;

    always_comb begin
        bst_d     = bst_q;
        // the first frac slots of every bit are one cycle longer
        extra     = CMP_W'(bst_q.slot) < CMP_W'(frac);
        last_cyc  = CNT_W'(div) + CNT_W'(extra);
        slot_end  = (bst_q.cyc == last_cyc);
        last_slot = (bst_q.slot == SLOT_W'(SLOTS - 1));
        bit_tick  = run && slot_end && last_slot;

        if (restart || !run) begin
            bst_d = '0;
        end else if (slot_end) begin
            bst_d.cyc  = '0;
            bst_d.slot = last_slot ? '0 : bst_q.slot + 1'b1;
        end else begin
            bst_d.cyc = bst_q.cyc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bst_q <= '0;
        else        bst_q <= bst_d;
    end

    // period monitor: cycles from restart or previous tick to this tick
    logic [PER_W-1:0] per_q;
    logic [PER_W-1:0] per_exp;

    assign per_exp = (PER_W'(div) + PER_W'(1)) * PER_W'(SLOTS) + PER_W'(frac);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   per_q <= '0;
        else if (restart || bit_tick) per_q <= '0;
        else if (run)                 per_q <= per_q + 1'b1;
    end

    assert_bit_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && !restart) |-> (per_q == per_exp - PER_W'(1)));

endmodule

// File: rtl/futx_frame.sv
module futx_frame
    import futx_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [FRAC_W-1:0] cfg_frac,
    input  logic [LINE_W-1:0] cfg_line,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              bit_tick,
    output logic              in_ready,
    output logic              txd,
    output logic              buf_empty,
    output logic              tx_empty,
    output logic              busy,
    output logic              load,
    output logic [DIV_W-1:0]  lat_div,
    output logic [FRAC_W-1:0] lat_frac
);

    typedef struct packed {
        fstate_e           st;
        logic [DATA_W-1:0] hold;
        logic              hold_vld;
        logic [DATA_W-1:0] shift;
        logic [IDX_W-1:0]  idx;
        logic              stop_idx;
        logic              par;
        fmt_t              fmt;
        logic [DIV_W-1:0]  div;
        logic [FRAC_W-1:0] frac;
        logic              txd;
    } fr_t;

    fr_t               fr_d, fr_q;
    fmt_t              fmt_new;
    logic [DATA_W-1:0] wmask;
    logic [DATA_W-1:0] masked;
    logic              accept;
    logic              frame_done;

    // line bit 4 carries no function
    logic              line_unused;
    assign line_unused = cfg_line[4];

    always_comb begin
        fr_d       = fr_q;
        fmt_new    = decode_line(cfg_line);
        wmask      = {DATA_W{1'b1}} >> (IDX_W'(DATA_W - 1) - fmt_new.last_idx);
        masked     = fr_q.hold & wmask;
        accept     = in_valid && !fr_q.hold_vld;
        frame_done = bit_tick && (fr_q.st == FS_STOP) &&
                     (fr_q.stop_idx == fr_q.fmt.two_stop);
        load       = fr_q.hold_vld && (cfg_div != '0) &&
                     ((fr_q.st == FS_IDLE) || frame_done);

        if (bit_tick) begin
            case (fr_q.st)
                FS_START: begin
                    fr_d.st  = FS_DATA;
                    fr_d.idx = '0;
                end
                FS_DATA: begin
                    fr_d.shift = {1'b0, fr_q.shift[DATA_W-1:1]};
                    if (fr_q.idx == fr_q.fmt.last_idx) begin
                        fr_d.st       = fr_q.fmt.par_en ? FS_PARITY : FS_STOP;
                        fr_d.stop_idx = 1'b0;
                    end else begin
                        fr_d.idx = fr_q.idx + 1'b1;
                    end
                end
                FS_PARITY: begin
                    fr_d.st       = FS_STOP;
                    fr_d.stop_idx = 1'b0;
                end
                FS_STOP: begin
                    if (frame_done) fr_d.st       = FS_IDLE;
                    else            fr_d.stop_idx = 1'b1;
                end
                default: fr_d.st = FS_IDLE;
            endcase
        end

        if (load) begin
            fr_d.st       = FS_START;
            fr_d.shift    = masked;
            fr_d.fmt      = fmt_new;
            fr_d.div      = cfg_div;
            fr_d.frac     = cfg_frac;
            fr_d.par      = fmt_new.par_even ? (^masked) : ~(^masked);
            fr_d.hold_vld = 1'b0;
            fr_d.idx      = '0;
            fr_d.stop_idx = 1'b0;
        end

        if (accept) begin
            fr_d.hold     = in_data;
            fr_d.hold_vld = 1'b1;
        end

        case (fr_d.st)
            FS_START:  fr_d.txd = 1'b0;
            FS_DATA:   fr_d.txd = fr_d.shift[0];
            FS_PARITY: fr_d.txd = fr_d.par;
            default:   fr_d.txd = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q     <= '0;
            fr_q.txd <= 1'b1;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign in_ready  = !fr_q.hold_vld;
    assign buf_empty = !fr_q.hold_vld;
    assign tx_empty  = (fr_q.st == FS_IDLE) && !fr_q.hold_vld;
    assign busy      = (fr_q.st != FS_IDLE);
    assign txd       = fr_q.txd;
    assign lat_div   = fr_q.div;
    assign lat_frac  = fr_q.frac;

    assert_idle_line_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_q.st == FS_IDLE) |-> fr_q.txd);

    assert_start_bit_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_q.st == FS_START) |-> !fr_q.txd);

    assert_zero_div_waits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((fr_q.st == FS_IDLE) && fr_q.hold_vld && (cfg_div == '0))
        |=> ((fr_q.st == FS_IDLE) && fr_q.hold_vld));

    assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((fr_q.st != FS_IDLE) && !load)
        |=> ($stable(fr_q.fmt) && $stable(fr_q.div) && $stable(fr_q.frac)));

    assert_accept_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (!buf_empty && !tx_empty));

    assert_back_to_back_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && fr_q.hold_vld && (cfg_div != '0)) |=> (fr_q.st == FS_START));

endmodule

// File: rtl/frac_uart_tx.sv
module frac_uart_tx
    import futx_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 3,
    parameter int SLOTS  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [FRAC_W-1:0] cfg_frac,
    input  logic [LINE_W-1:0] cfg_line,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              txd,
    output logic              tx_empty,
    output logic              buf_empty
);

    logic              busy;
    logic              load;
    logic              bit_tick;
    logic [DIV_W-1:0]  lat_div;
    logic [FRAC_W-1:0] lat_frac;

    futx_frame #(
        .DIV_W  (DIV_W),
        .FRAC_W (FRAC_W)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_div   (cfg_div),
        .cfg_frac  (cfg_frac),
        .cfg_line  (cfg_line),
        .in_data   (tx_data),
        .in_valid  (tx_valid),
        .bit_tick  (bit_tick),
        .in_ready  (tx_ready),
        .txd       (txd),
        .buf_empty (buf_empty),
        .tx_empty  (tx_empty),
        .busy      (busy),
        .load      (load),
        .lat_div   (lat_div),
        .lat_frac  (lat_frac)
    );

    futx_baud #(
        .DIV_W  (DIV_W),
        .FRAC_W (FRAC_W),
        .SLOTS  (SLOTS)
    ) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .restart  (load),
        .div      (lat_div),
        .frac     (lat_frac),
        .bit_tick (bit_tick)
    );

    assert_ready_mirrors_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready == buf_empty);

endmodule

// File: tb/sim_frac_uart_tx.sv
module sim_frac_uart_tx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_div = 16'd1;
    logic [2:0]  cfg_frac = 3'd0;
    logic [5:0]  cfg_line = 6'b000011;
    logic [7:0]  tx_data = 8'h00;
    logic        tx_valid = 1'b0;
    logic        tx_ready, txd, tx_empty, buf_empty;

    int n_checks = 0;
    int n_fails  = 0;
    logic buf_start;

    always #5 clk = ~clk;

    frac_uart_tx u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_div   (cfg_div),
        .cfg_frac  (cfg_frac),
        .cfg_line  (cfg_line),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .txd       (txd),
        .tx_empty  (tx_empty),
        .buf_empty (buf_empty)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [11:0] frame_bits(input logic [7:0] d, input logic [5:0] ln);
        logic [11:0] b;
        logic p;
        int wl;
        b  = '1;
        b[0] = 1'b0;
        p  = 1'b0;
        wl = int'(ln[1:0]) + 5;
        for (int i = 0; i < wl; i++) begin
            b[1+i] = d[i];
            p = p ^ d[i];
        end
        if (ln[5]) b[1+wl] = ln[3] ? p : ~p;
        return b;
    endfunction

    function automatic int frame_len(input logic [5:0] ln);
        return 1 + int'(ln[1:0]) + 5 + int'(ln[5]) + (ln[2] ? 2 : 1);
    endfunction

    function automatic int bit_period(input logic [15:0] dv, input logic [2:0] fr);
        return 16 * (int'(dv) + 1) + int'(fr);
    endfunction

    // byte accepted on the next rising edge; flags checked one cycle later
    task automatic send(input logic [7:0] d, input logic [5:0] ln,
                        input logic [15:0] dv, input logic [2:0] fr, input string req);
        @(negedge clk);
        cfg_line = ln; cfg_div = dv; cfg_frac = fr;
        tx_data  = d;  tx_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        check(!buf_empty && !tx_empty, req, "flags low after accept (R7)",
              {buf_empty, tx_empty}, 0);
    endtask

    // called right after the loading edge; samples every cycle of the frame
    task automatic check_wave(input logic [11:0] bits, input int nb, input int per,
                              input int inj_at, input logic [7:0] id, input logic [5:0] il,
                              input logic [15:0] idv, input logic [2:0] ifr, input string req);
        int bad_c;
        int act_v, exp_v;
        bad_c = -1; act_v = 0; exp_v = 0;
        for (int c = 0; c < nb * per; c++) begin
            @(negedge clk);
            if (c == 0) buf_start = buf_empty;
            if (bad_c < 0 && (txd !== bits[c/per] || tx_empty !== 1'b0)) begin
                bad_c = c;
                act_v = {tx_empty, txd};
                exp_v = {1'b0, bits[c/per]};
            end
            if (c == inj_at) begin
                tx_valid = 1'b1; tx_data = id;
                cfg_line = il; cfg_div = idv; cfg_frac = ifr;
            end
            if (c == inj_at + 1) tx_valid = 1'b0;
        end
        check(bad_c < 0, req, $sformatf("{tx_empty,txd} at frame cycle %0d", bad_c),
              act_v, exp_v);
    endtask

    task automatic tail(input string req);
        @(negedge clk);
        check(tx_empty && buf_empty && txd && tx_ready, req,
              "idle after last stop (R7 R6)", {tx_empty, buf_empty, txd, tx_ready}, 15);
    endtask

    task automatic run_frame(input logic [7:0] d, input logic [5:0] ln,
                             input logic [15:0] dv, input logic [2:0] fr, input string req);
        send(d, ln, dv, fr, req);
        @(posedge clk);
        check_wave(frame_bits(d, ln), frame_len(ln), bit_period(dv, fr),
                   -1, 8'h00, ln, dv, fr, req);
        check(buf_start == 1'b1, req, "buf_empty on load edge (R7)", buf_start, 1);
        tail(req);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(txd == 1'b1, "R8", "txd after reset", txd, 1);
        check(tx_empty == 1'b1, "R8", "tx_empty after reset", tx_empty, 1);
        check(buf_empty == 1'b1, "R8", "buf_empty after reset", buf_empty, 1);
        check(tx_ready == 1'b1, "R8", "tx_ready after reset", tx_ready, 1);
    endtask

    // R1 R3 R6: 8 data, no parity, one stop, integer divisor only
    task automatic t_basic();
        run_frame(8'hA5, 6'b000011, 16'd1, 3'd0, "R1_R3_R6");
    endtask

    // R1 R4 R5: 7 data, even parity, two stops, fractional 5
    task automatic t_frac_even_two_stop();
        run_frame(8'h3C, 6'b101110, 16'd2, 3'd5, "R1_R4_R5");
    endtask

    // R3 R5: 5 data of 0xFF (upper bits dropped), odd parity, fractional 7
    task automatic t_short_odd();
        run_frame(8'hFF, 6'b100000, 16'd1, 3'd7, "R3_R5");
    endtask

    // R5: bits 3 and 4 set with parity off change nothing
    task automatic t_ignored_bits();
        run_frame(8'h96, 6'b011011, 16'd1, 3'd1, "R5");
    endtask

    // R2: zero divisor holds the byte, line stays high
    task automatic t_zero_div();
        int bad;
        bad = 0;
        send(8'h4E, 6'b000011, 16'd0, 3'd0, "R2");
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (txd !== 1'b1 || buf_empty !== 1'b0 || tx_ready !== 1'b0) bad++;
        end
        check(bad == 0, "R2", "cycles with line low or byte released", bad, 0);
        cfg_div = 16'd1;
        @(posedge clk);
        check_wave(frame_bits(8'h4E, 6'b000011), frame_len(6'b000011),
                   bit_period(16'd1, 3'd0), -1, 8'h00, 6'b000011, 16'd1, 3'd0, "R2");
        tail("R2");
    endtask

    // R9 R10: second byte and new format arrive mid-frame
    task automatic t_back_to_back();
        send(8'h5A, 6'b000011, 16'd1, 3'd2, "R10");
        @(posedge clk);
        check_wave(frame_bits(8'h5A, 6'b000011), frame_len(6'b000011),
                   bit_period(16'd1, 3'd2), 40, 8'hC3, 6'b101110, 16'd1, 3'd6, "R9");
        check(buf_empty == 1'b0 && tx_ready == 1'b0, "R10", "second byte waiting",
              {buf_empty, tx_ready}, 0);
        @(posedge clk);
        check_wave(frame_bits(8'hC3, 6'b101110), frame_len(6'b101110),
                   bit_period(16'd1, 3'd6), -1, 8'h00, 6'b101110, 16'd1, 3'd6, "R10");
        check(buf_start == 1'b1, "R10", "buf_empty when second frame loads", buf_start, 1);
        tail("R10");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_frac_even_two_stop();
        t_short_odd();
        t_ignored_bits();
        t_zero_div();
        t_back_to_back();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

endmodule